// File: doc/BRIEF.md
# Tick-Driven 8-Bit Timer with Compare Unit

The block is an up-counter that advances by one on every cycle in which the tick strobe is high. The tick strobe comes from a prescaler or edge detector outside the block. A mode input chooses how the count ends its period:

- **Wrap mode:** the count runs to its all-ones value and then starts again at zero.
- **Clear-on-compare mode:** the count returns to zero on the tick that finds it equal to the compare register.

Software can load the count and the compare value in any cycle.

Two events are detected, rollover and compare match. Each event sets its own sticky flag. A flag raises its interrupt line when its enable is high, and a per-flag acknowledge clears it. In clear-on-compare mode, a compare match can toggle, clear or set a waveform pin, or leave it untouched. A one-cycle trigger pulse, sourced from either the rollover or the match, is available to start a downstream converter.

Top module: `tick_timer8`

## Requirements
- R1: After reset the count, compare value, both flags, the pin level and the trigger are all 0.
- R2: A tick with no count write adds one to the count. With no tick and no write, the count holds its value.
- R3: With mode code 00 (codes 10 and 11 act the same), a tick at count 0xFF gives 0x00 and sets the overflow flag. This flag is set by any 0xFF-to-0x00 tick in either mode.
- R4: With mode code 01, a tick while the count equals the compare value loads 0. In any mode, such a tick sets the compare-match flag.
- R5: Each interrupt output is high exactly while its flag and its enable are both high. The two interrupts are independent.
- R6: An acknowledge clears its flag at the next edge. A set event in the same cycle wins, and the flag stays 1.
- R7: A count write takes effect at the next edge instead of the increment. It suppresses that cycle's rollover and match events.
- R8: A compare write takes effect at the next edge, and the new value is used for every later comparison.
- R9: In mode 01, the pin action code on a match works as follows: 01 toggles the pin, 10 drives it 0, 11 drives it 1, and 00 leaves it unchanged. Output enable is low only for code 00. In other modes a match leaves the pin unchanged.
- R10: The trigger is high for the one cycle after an event. Its source is the match event when the select is 1 and the rollover when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count advance strobe |
| mode_i | input | 2 | 01 clear-on-compare, otherwise wrap |
| cnt_we_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | 8 | Count write value |
| cmp_we_i | input | 1 | Compare write strobe |
| cmp_wdata_i | input | 8 | Compare write value |
| pin_act_i | input | 2 | Pin action on match |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| cmp_ie_i | input | 1 | Match interrupt enable |
| ovf_ack_i | input | 1 | Overflow flag acknowledge |
| cmp_ack_i | input | 1 | Match flag acknowledge |
| trig_sel_i | input | 1 | Trigger source, 1 match, 0 rollover |
| count_o | output | 8 | Current count |
| cmp_o | output | 8 | Current compare value |
| ovf_flag_o | output | 1 | Overflow flag |
| cmp_flag_o | output | 1 | Match flag |
| ovf_irq_o | output | 1 | Overflow interrupt |
| cmp_irq_o | output | 1 | Match interrupt |
| pin_o | output | 1 | Waveform pin level |
| pin_oe_o | output | 1 | Waveform pin output enable |
| trig_o | output | 1 | Converter trigger pulse |

## Verification
The bench targets several corner cases:

- **Compare value of zero:** a design that checked the incremented value instead of the current one would let the count run past 0 rather than pinning it there.
- **Compare value of 0xFF:** the match tick must raise both flags. A design that treated the clear as something other than a rollover would miss the overflow flag.
- **Compare value below a freshly written count:** the count must wrap through 0xFF and must not match.
- **Same-cycle collisions:** an acknowledge arriving with a set, and a count write arriving with a tick, are both driven. A wrong priority loses a flag or lets the count advance past the written value.
- **Pin codes and trigger select:** every pin action code is exercised, and the trigger select is checked both ways. A swapped decode shows up as the wrong pin level or a missing pulse.

// File: rtl/tick_timer8_pkg.sv
package tick_timer8_pkg;
  typedef enum logic [1:0] {
    PIN_KEEP = 2'b00,
    PIN_FLIP = 2'b01,
    PIN_LOW  = 2'b10,
    PIN_HIGH = 2'b11
  } pin_act_e;

  localparam logic [1:0] MODE_CLR = 2'b01;
  localparam int unsigned EV_OVF = 0;
  localparam int unsigned EV_CMP = 1;
  localparam int unsigned N_EV   = 2;
endpackage

// File: rtl/tick_timer8_count.sv
module tick_timer8_count #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_mode_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         cmp_we_i,
  input  logic [W-1:0] cmp_wdata_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cmp_o,
  output logic         ovf_ev_o,
  output logic         match_ev_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d, cmp_q;
  logic         adv;

  assign adv        = tick_i & ~we_i;
  assign match_ev_o = adv & (cnt_q == cmp_q);
  assign ovf_ev_o   = adv & (cnt_q == MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (we_i)                          cnt_d = wdata_i;
    else if (match_ev_o && clr_mode_i) cnt_d = '0;
    else if (adv)                      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (cmp_we_i) cmp_q <= cmp_wdata_i;
    end
  end

  assign cnt_o = cnt_q;
  assign cmp_o = cmp_q;

  // R2
  hold_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !we_i) |=> $stable(cnt_q));
  // R3
  wrap_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !we_i && cnt_q == MAX) |=> (cnt_q == '0));
  // R4
  clr_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !we_i && clr_mode_i && cnt_q == cmp_q) |=> (cnt_q == '0));
  // R7
  wr_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (cnt_q == $past(wdata_i)));
  // R8
  cmp_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_we_i |=> (cmp_q == $past(cmp_wdata_i)));
endmodule

// File: rtl/tick_timer8_flag.sv
module tick_timer8_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  input  logic ie_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  // set outranks acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (set_i)   flag_q <= 1'b1;
    else if (ack_i)   flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ie_i;

  // R6
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  // R6
  ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !set_i) |=> !flag_q);
  // R5
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_q |-> !irq_o);
endmodule

// File: rtl/tick_timer8_wave.sv
module tick_timer8_wave
  import tick_timer8_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       match_ev_i,
  input  logic       clr_mode_i,
  input  logic [1:0] pin_act_i,
  output logic       pin_o,
  output logic       pin_oe_o
);
  pin_act_e act;
  logic     pin_q, pin_d;

  assign act = pin_act_e'(pin_act_i);

  always_comb begin
    pin_d = pin_q;
    if (match_ev_i && clr_mode_i) begin
      unique case (act)
        PIN_FLIP: pin_d = ~pin_q;
        PIN_LOW:  pin_d = 1'b0;
        PIN_HIGH: pin_d = 1'b1;
        default:  pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_d;
  end

  assign pin_o    = pin_q;
  assign pin_oe_o = (act != PIN_KEEP);

  // R9
  flip_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_ev_i && clr_mode_i && pin_act_i == 2'b01) |=> (pin_q != $past(pin_q)));
  // R9
  keep_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_act_i == 2'b00 || !clr_mode_i) |=> $stable(pin_q));
endmodule

// File: rtl/tick_timer8.sv
module tick_timer8
  import tick_timer8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [1:0]   mode_i,
  input  logic         cnt_we_i,
  input  logic [W-1:0] cnt_wdata_i,
  input  logic         cmp_we_i,
  input  logic [W-1:0] cmp_wdata_i,
  input  logic [1:0]   pin_act_i,
  input  logic         ovf_ie_i,
  input  logic         cmp_ie_i,
  input  logic         ovf_ack_i,
  input  logic         cmp_ack_i,
  input  logic         trig_sel_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] cmp_o,
  output logic         ovf_flag_o,
  output logic         cmp_flag_o,
  output logic         ovf_irq_o,
  output logic         cmp_irq_o,
  output logic         pin_o,
  output logic         pin_oe_o,
  output logic         trig_o
);
  logic            clr_mode;
  logic [N_EV-1:0] ev, ack, ie, flag, irq;
  logic            trig_q;

  assign clr_mode = (mode_i == MODE_CLR);

  tick_timer8_count #(.W(W)) u_count (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .clr_mode_i  (clr_mode),
    .we_i        (cnt_we_i),
    .wdata_i     (cnt_wdata_i),
    .cmp_we_i    (cmp_we_i),
    .cmp_wdata_i (cmp_wdata_i),
    .cnt_o       (count_o),
    .cmp_o       (cmp_o),
    .ovf_ev_o    (ev[EV_OVF]),
    .match_ev_o  (ev[EV_CMP])
  );

  assign ack[EV_OVF] = ovf_ack_i;
  assign ack[EV_CMP] = cmp_ack_i;
  assign ie[EV_OVF]  = ovf_ie_i;
  assign ie[EV_CMP]  = cmp_ie_i;

  for (genvar g = 0; g < N_EV; g++) begin : g_flag
    tick_timer8_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (ev[g]),
      .ack_i  (ack[g]),
      .ie_i   (ie[g]),
      .flag_o (flag[g]),
      .irq_o  (irq[g])
    );
  end

  assign ovf_flag_o = flag[EV_OVF];
  assign cmp_flag_o = flag[EV_CMP];
  assign ovf_irq_o  = irq[EV_OVF];
  assign cmp_irq_o  = irq[EV_CMP];

  tick_timer8_wave u_wave (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .match_ev_i (ev[EV_CMP]),
    .clr_mode_i (clr_mode),
    .pin_act_i  (pin_act_i),
    .pin_o      (pin_o),
    .pin_oe_o   (pin_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= trig_sel_i ? ev[EV_CMP] : ev[EV_OVF];
  end

  assign trig_o = trig_q;

  // R10
  trig_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_sel_i && ev[EV_CMP]) |=> trig_o);
  // R10
  trig_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_sel_i && ev[EV_OVF]) |=> trig_o);
  // R10
  trig_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev == '0) |=> !trig_o);
endmodule

// File: tb/tick_timer8_test.sv
module tick_timer8_test;
  typedef struct packed {
    logic [1:0] mode;
    logic [7:0] cmp;
    logic [7:0] start;
    logic [8:0] nt;
    logic [7:0] exp_cnt;
    logic       exp_ovf;
    logic       exp_cmpf;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 8'h80, 8'h10, 9'd5,   8'h15, 1'b0, 1'b0},
    '{2'd0, 8'h80, 8'hFE, 9'd3,   8'h01, 1'b1, 1'b0},
    '{2'd1, 8'h05, 8'h03, 9'd3,   8'h00, 1'b0, 1'b1},
    '{2'd1, 8'h05, 8'h03, 9'd5,   8'h02, 1'b0, 1'b1},
    '{2'd1, 8'h00, 8'h00, 9'd4,   8'h00, 1'b0, 1'b1},
    '{2'd1, 8'hFF, 8'hFD, 9'd3,   8'h00, 1'b1, 1'b1},
    '{2'd1, 8'h10, 8'h20, 9'd224, 8'h00, 1'b1, 1'b0},
    '{2'd0, 8'h42, 8'h40, 9'd4,   8'h44, 1'b0, 1'b1},
    '{2'd2, 8'h03, 8'h02, 9'd3,   8'h05, 1'b0, 1'b1},
    '{2'd0, 8'h00, 8'hFF, 9'd0,   8'hFF, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 0, cnt_we = 0, cmp_we = 0;
  logic [1:0] mode = 0, pin_act = 0;
  logic [7:0] cnt_wd = 0, cmp_wd = 0;
  logic       ovf_ie = 0, cmp_ie = 0, ovf_ack = 0, cmp_ack = 0, trig_sel = 0;
  logic [7:0] count, cmpv;
  logic       ovf_f, cmp_f, ovf_irq, cmp_irq, pin, pin_oe, trig;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tick_timer8 uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .mode_i(mode),
    .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wd), .cmp_we_i(cmp_we), .cmp_wdata_i(cmp_wd),
    .pin_act_i(pin_act), .ovf_ie_i(ovf_ie), .cmp_ie_i(cmp_ie),
    .ovf_ack_i(ovf_ack), .cmp_ack_i(cmp_ack), .trig_sel_i(trig_sel),
    .count_o(count), .cmp_o(cmpv), .ovf_flag_o(ovf_f), .cmp_flag_o(cmp_f),
    .ovf_irq_o(ovf_irq), .cmp_irq_o(cmp_irq), .pin_o(pin), .pin_oe_o(pin_oe),
    .trig_o(trig)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    cnt_we = 1; cnt_wd = v; cyc(); cnt_we = 0;
  endtask

  task automatic tk(input int n);
    tick = 1; repeat (n) cyc(); tick = 0;
  endtask

  task automatic clr_flags();
    ovf_ack = 1; cmp_ack = 1; cyc(); ovf_ack = 0; cmp_ack = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    #1;
    chk("R1 count", count, 0);
    chk("R1 cmp", cmpv, 0);
    chk("R1 flags", {ovf_f, cmp_f}, 0);
    chk("R1 pin/trig", {pin, trig}, 0);
    repeat (3) cyc();
    rst_n = 1;
    cyc();

    // table walk: R2 R3 R4 R5
    ovf_ie = 1; cmp_ie = 1;
    for (int i = 0; i < NV; i++) begin
      mode = VECS[i].mode;
      cnt_we = 1; cnt_wd = VECS[i].start;
      cmp_we = 1; cmp_wd = VECS[i].cmp;
      ovf_ack = 1; cmp_ack = 1;
      cyc();
      cnt_we = 0; cmp_we = 0; ovf_ack = 0; cmp_ack = 0;
      tk(int'(VECS[i].nt));
      chk("R2/R3/R4 count", count, VECS[i].exp_cnt);
      chk("R3 ovf flag", ovf_f, VECS[i].exp_ovf);
      chk("R4 cmp flag", cmp_f, VECS[i].exp_cmpf);
      chk("R5 irq", {ovf_irq, cmp_irq}, {VECS[i].exp_ovf, VECS[i].exp_cmpf});
    end
    ovf_ie = 0; cmp_ie = 0;

    // R2 hold without tick
    mode = 0; wr_cnt(8'h33); repeat (3) cyc();
    chk("R2 hold", count, 8'h33);

    // R6 set beats ack
    mode = 1; cmp_we = 1; cmp_wd = 8'h02; cyc(); cmp_we = 0;
    wr_cnt(8'h02); clr_flags();
    tick = 1; cmp_ack = 1; cyc(); tick = 0;
    chk("R6 set wins", cmp_f, 1);
    cyc(); cmp_ack = 0;
    chk("R6 ack clears", cmp_f, 0);
    mode = 0; wr_cnt(8'hFF); tk(1);
    chk("R6 ovf set", ovf_f, 1);
    ovf_ack = 1; cyc(); ovf_ack = 0;
    chk("R6 ovf ack", ovf_f, 0);

    // R5 enable gating
    mode = 1; wr_cnt(8'h02); tk(1);
    cmp_ie = 0; #1;
    chk("R5 masked", cmp_irq, 0);
    cmp_ie = 1; ovf_ie = 1; #1;
    chk("R5 enabled", {ovf_irq, cmp_irq}, 2'b01);
    cmp_ie = 0; ovf_ie = 0;

    // R7 write beats tick, no event
    cmp_we = 1; cmp_wd = 8'h05; cyc(); cmp_we = 0;
    wr_cnt(8'h05); clr_flags();
    tick = 1; cnt_we = 1; cnt_wd = 8'h09; cyc(); tick = 0; cnt_we = 0;
    chk("R7 count", count, 8'h09);
    chk("R7 no match", cmp_f, 0);

    // R8 compare change mid-run
    cmp_we = 1; cmp_wd = 8'h30; cyc(); cmp_we = 0;
    wr_cnt(8'h08); clr_flags();
    cmp_we = 1; cmp_wd = 8'h0A; cyc(); cmp_we = 0;
    chk("R8 cmp value", cmpv, 8'h0A);
    tk(3);
    chk("R8 count", count, 8'h00);
    chk("R8 flag", cmp_f, 1);

    // R9 pin actions
    cmp_we = 1; cmp_wd = 8'h01; cyc(); cmp_we = 0;
    pin_act = 2'b11; wr_cnt(8'h01); tk(1);
    chk("R9 set", pin, 1);
    pin_act = 2'b10; wr_cnt(8'h01); tk(1);
    chk("R9 clear", pin, 0);
    pin_act = 2'b01; wr_cnt(8'h01); tk(1);
    chk("R9 toggle1", pin, 1);
    wr_cnt(8'h01); tk(1);
    chk("R9 toggle2", pin, 0);
    chk("R9 oe on", pin_oe, 1);
    pin_act = 2'b00; wr_cnt(8'h01); tk(1);
    chk("R9 keep", pin, 0);
    chk("R9 oe off", pin_oe, 0);
    mode = 0; pin_act = 2'b11; wr_cnt(8'h01); tk(1);
    chk("R9 wrap mode keep", pin, 0);

    // R10 trigger source
    mode = 1; trig_sel = 1;
    cmp_we = 1; cmp_wd = 8'h03; cyc(); cmp_we = 0;
    wr_cnt(8'h03); tk(1);
    chk("R10 match pulse", trig, 1);
    cyc();
    chk("R10 one cycle", trig, 0);
    trig_sel = 0; wr_cnt(8'h03); tk(1);
    chk("R10 match ignored", trig, 0);
    mode = 0; wr_cnt(8'hFF); tk(1);
    chk("R10 ovf pulse", trig, 1);

    finish_run();
  end
endmodule